// File: doc/BRIEF.md
# Dual-Bridge Fault Supervisor

This block watches the two full-bridge output stages of a stepper driver and reports faults on two active-low error lines. Each bridge keeps its own open-load and short-to-ground fault flags. Analog sensing is done elsewhere. Recirculation after a direction reversal, short-to-ground detection and the thermal warning and shutdown levels all arrive here as digital signals. Along with them come the direction bit and the two-bit current code of each bridge, as driven by the controller.

An open load shows up as missing inductive recirculation after a direction reversal. The block opens an observation window at every reversal. It flags the bridge if no recirculation pulse arrives in that window. It also flags the bridge if the reversal happened in hold mode, or if the current code moved too close in time to the reversal. A short to ground must persist for a qualification time before its flag is set. Once set, it disables that bridge until the flag is cleared. Both flags of a bridge clear a short time after a new reversal, or after the current code is held at "off". Because flags are kept per bridge, a controller can find a faulty bridge by enabling the bridges one at a time. All timings are parameters in microseconds, scaled by the clock rate.

Top module: `bridge_fault_monitor`

## Requirements
- R1: After reset, all fault flags are 0, both error lines are high, and every bridge enable is high.
- R2: A direction reversal followed by a recirculation pulse inside the open-load window (T_OL = 15 µs of cycles) leaves the open-load flag at 0. This applies only when the current code has been stable for at least T_IP (12 µs) and stays stable for T_PI (5 µs).
- R3: A direction reversal with no recirculation pulse sets the open-load flag T_OL cycles after the reversal edge, and not earlier. With no short flagged and no warning, the error lines then read err1_n=0, err2_n=1.
- R4: A reversal made while the bridge's current code is hold (code 2'b10, where bit 1 is the upper code bit) sets the open-load flag even if recirculation is seen.
- R5: A current-code change less than T_PI after a reversal, or a reversal less than T_IP after a code change, sets the open-load flag at the end of the window even if recirculation is seen.
- R6: A short-to-ground level held continuously for T_SCC (30 µs) sets the bridge's short flag. If a reversal occurs while the short is present, the flag is set T_SCD (45 µs) after that reversal. When any short flag is set and there is no warning, the error lines read err1_n=1, err2_n=0, whatever the open-load flags show.
- R7: While a bridge's short flag is set, its bridge enable is 0, even after the short input goes away. The enable returns to 1 only when the flag is cleared.
- R8: A direction reversal clears both flags of that bridge T_RP (3 µs) cycles later. Holding the current code at off (2'b11) for T_RI (1 µs) clears both flags. While the code is off, shorts are ignored and no open-load window runs.
- R9: The thermal warning input forces err1_n=0 and err2_n=0 one cycle later, above every other status.
- R10: The thermal shutdown input drives every bridge enable to 0 while it is high.
- R11: Flags are independent per bridge. fault_status bit 2b is the open-load flag of bridge b and bit 2b+1 is its short flag, and a fault on one bridge changes no bit of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | NB | Direction bit per bridge |
| code | input | 2*NB | Current code per bridge, bits 2b+1:2b for bridge b (11 off, 10 hold, 01 normal, 00 boost) |
| recirc | input | NB | Recirculation-detected pulse per bridge |
| short_det | input | NB | Short-to-ground detect level per bridge |
| temp_warn | input | 1 | Thermal pre-alarm level |
| temp_shut | input | 1 | Thermal shutdown level |
| err1_n | output | 1 | Error line 1, active low |
| err2_n | output | 1 | Error line 2, active low |
| bridge_en | output | NB | Output-stage enable per bridge |
| fault_status | output | 2*NB | Per-bridge {short, open-load} flags for test observation |

## Verification
The bench checks each flag at both ends of its latency. One sample falls just before the expected set or clear edge and one just after it, so a window that is off by more than a couple of cycles is caught. Three cases look healthy but must still flag open load: a code change shortly after a reversal, a reversal shortly after a code change, and a reversal in hold mode. A design that only tracks recirculation would pass a plain reversal test and miss all three. Other checks confirm that the short disable survives removal of the short, that the short indication beats open load on the error lines, that the warning beats both, and that a fault on bridge 1 never reaches the bits or enable of bridge 0.

// File: rtl/bfm_pkg.sv
// Shared constants for the bridge fault supervisor.
// Assumes current codes are two bits with the upper bit first.
package bfm_pkg;
    localparam logic [1:0] CODE_OFF  = 2'b11;
    localparam logic [1:0] CODE_HOLD = 2'b10;

    // Convert a microsecond figure to clock cycles.
    function automatic int us_to_cyc(input int us, input int cyc_per_us);
        return us * cyc_per_us;
    endfunction
endpackage

// File: rtl/bfm_bridge_cell.sv
// Fault flags for one bridge: open-load window after a reversal and
// short-to-ground qualification, plus delayed clearing.
// Assumes all timing parameters are >= 2 and T_SCC < T_SCD, T_PI < T_OL.
module bfm_bridge_cell
    import bfm_pkg::*;
#(
    parameter int T_OL  = 30,
    parameter int T_SCD = 90,
    parameter int T_SCC = 60,
    parameter int T_RP  = 6,
    parameter int T_RI  = 2,
    parameter int T_PI  = 10,
    parameter int T_IP  = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir,
    input  logic [1:0] code,
    input  logic       recirc,
    input  logic       short_det,
    output logic       ol_flag,
    output logic       sc_flag
);
    localparam int CW = $clog2(T_SCD + 2);
    localparam logic [CW-1:0] K_OL   = CW'(T_OL);
    localparam logic [CW-1:0] K_SCM1 = CW'(T_SCD - 1);
    localparam logic [CW-1:0] K_SOFS = CW'(T_SCD - T_SCC);
    localparam logic [CW-1:0] K_RP   = CW'(T_RP);
    localparam logic [CW-1:0] K_RI   = CW'(T_RI);
    localparam logic [CW-1:0] K_PIW  = CW'(T_OL - T_PI);
    localparam logic [CW-1:0] K_IP   = CW'(T_IP);
    localparam logic [CW-1:0] K_IPM1 = CW'(T_IP - 1);

    logic          dir_q, sc_act_q;
    logic [1:0]    code_q;
    logic [CW-1:0] win_cnt, clr_cnt, age, sc_cnt, ri_cnt;
    logic          seen, spoil, hold_mk, ol_q, sc_q;

    logic dir_evt, code_chg, is_off, sc_act, sc_rise;
    logic off_clr, dir_clr, clr_now, ol_set, sc_set;

    // Event decode for the current cycle.
    always_comb begin
        dir_evt  = dir ^ dir_q;
        code_chg = (code != code_q);
        is_off   = (code == CODE_OFF);
        sc_act   = short_det & ~is_off;
        sc_rise  = sc_act & ~sc_act_q;
        off_clr  = is_off && (ri_cnt == K_RI);
        dir_clr  = (clr_cnt == CW'(1));
        clr_now  = off_clr | dir_clr;
        ol_set   = (win_cnt == CW'(1)) && (!seen || spoil || hold_mk);
        sc_set   = sc_act && (sc_cnt == K_SCM1) && !sc_q;
    end

    // Input history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= dir;
            code_q   <= code;
            sc_act_q <= 1'b0;
        end else begin
            dir_q    <= dir;
            code_q   <= code;
            sc_act_q <= sc_act;
        end
    end

    // Cycles since the last code change, saturating at T_IP.
    always_ff @(posedge clk) begin
        if (!rst_n)             age <= K_IP;
        else if (code_chg)      age <= '0;
        else if (age < K_IP)    age <= age + CW'(1);
    end

    // Time spent at the off code, saturating at T_RI.
    always_ff @(posedge clk) begin
        if (!rst_n || !is_off)  ri_cnt <= '0;
        else if (ri_cnt < K_RI) ri_cnt <= ri_cnt + CW'(1);
    end

    // Clear delay after a reversal.
    always_ff @(posedge clk) begin
        if (!rst_n)                clr_cnt <= '0;
        else if (dir_evt)          clr_cnt <= K_RP;
        else if (clr_cnt != '0)    clr_cnt <= clr_cnt - CW'(1);
    end

    // Open-load observation window and its qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n || is_off) begin
            win_cnt <= '0;
            seen    <= 1'b0;
            spoil   <= 1'b0;
            hold_mk <= 1'b0;
        end else if (dir_evt) begin
            win_cnt <= K_OL;
            seen    <= recirc;
            spoil   <= code_chg || (age < K_IPM1);
            hold_mk <= (code == CODE_HOLD);
        end else if (win_cnt != '0) begin
            win_cnt <= win_cnt - CW'(1);
            seen    <= seen | recirc;
            if (code_chg && (win_cnt > K_PIW)) spoil <= 1'b1;
        end
    end

    // Short qualification timer, restarted by reversals.
    always_ff @(posedge clk) begin
        if (!rst_n || !sc_act)     sc_cnt <= '0;
        else if (dir_evt)          sc_cnt <= '0;
        else if (sc_rise)          sc_cnt <= K_SOFS;
        else if (sc_cnt < K_SCM1)  sc_cnt <= sc_cnt + CW'(1);
    end

    // Fault flip-flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ol_q <= 1'b0;
            sc_q <= 1'b0;
        end else begin
            if (clr_now)     ol_q <= 1'b0;
            else if (ol_set) ol_q <= 1'b1;
            if (sc_set)       sc_q <= 1'b1;
            else if (clr_now) sc_q <= 1'b0;
        end
    end

    assign ol_flag = ol_q;
    assign sc_flag = sc_q;

    // R3: an open-load flag only appears as a window closes.
    a_r3_ol_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ol_q) |-> $past(win_cnt == CW'(1)));
    // R6: a short flag needs a live, ungated short input.
    a_r6_sc_needs_short: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sc_q) |-> $past(sc_act));
    // R7: a short flag persists until a clear condition.
    a_r7_sc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q && !clr_now) |=> sc_q);
endmodule

// File: rtl/bfm_status_enc.sv
// Maps per-bridge flags and the thermal warning onto two active-low lines.
// Priority: warning, then any short, then any open load. Registered outputs.
module bfm_status_enc #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] ol,
    input  logic [NB-1:0] sc,
    input  logic          temp_warn,
    output logic          err1_n,
    output logic          err2_n
);
    // Prioritised encoding of the combined status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err1_n <= 1'b1;
            err2_n <= 1'b1;
        end else if (temp_warn) begin
            err1_n <= 1'b0;
            err2_n <= 1'b0;
        end else if (|sc) begin
            err1_n <= 1'b1;
            err2_n <= 1'b0;
        end else if (|ol) begin
            err1_n <= 1'b0;
            err2_n <= 1'b1;
        end else begin
            err1_n <= 1'b1;
            err2_n <= 1'b1;
        end
    end

    // R9: the warning drives both lines low on the next cycle.
    a_r9_warn_low: assert property (@(posedge clk) disable iff (!rst_n)
        temp_warn |=> (!err1_n && !err2_n));
    // R6: a short dominates open load on the lines.
    a_r6_sc_dominant: assert property (@(posedge clk) disable iff (!rst_n)
        (!temp_warn && (|sc)) |=> (err1_n && !err2_n));
endmodule

// File: rtl/bridge_fault_monitor.sv
// Top of the dual-bridge fault supervisor: one fault cell per bridge,
// a status encoder, and the bridge enable gating.
// Assumes inputs are synchronous to clk.
module bridge_fault_monitor
    import bfm_pkg::*;
#(
    parameter int NB         = 2,
    parameter int CYC_PER_US = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NB-1:0]   dir,
    input  logic [2*NB-1:0] code,
    input  logic [NB-1:0]   recirc,
    input  logic [NB-1:0]   short_det,
    input  logic            temp_warn,
    input  logic            temp_shut,
    output logic            err1_n,
    output logic            err2_n,
    output logic [NB-1:0]   bridge_en,
    output logic [2*NB-1:0] fault_status
);
    localparam int T_OL  = us_to_cyc(15, CYC_PER_US);
    localparam int T_SCD = us_to_cyc(45, CYC_PER_US);
    localparam int T_SCC = us_to_cyc(30, CYC_PER_US);
    localparam int T_RP  = us_to_cyc(3,  CYC_PER_US);
    localparam int T_RI  = us_to_cyc(1,  CYC_PER_US);
    localparam int T_PI  = us_to_cyc(5,  CYC_PER_US);
    localparam int T_IP  = us_to_cyc(12, CYC_PER_US);

    logic [NB-1:0] ol, sc;

    for (genvar b = 0; b < NB; b++) begin : g_bridge
        bfm_bridge_cell #(
            .T_OL(T_OL), .T_SCD(T_SCD), .T_SCC(T_SCC), .T_RP(T_RP),
            .T_RI(T_RI), .T_PI(T_PI), .T_IP(T_IP)
        ) u_cell (
            .clk(clk), .rst_n(rst_n), .dir(dir[b]), .code(code[2*b +: 2]),
            .recirc(recirc[b]), .short_det(short_det[b]),
            .ol_flag(ol[b]), .sc_flag(sc[b])
        );
        // Status layout: open load low bit, short high bit.
        assign fault_status[2*b]   = ol[b];
        assign fault_status[2*b+1] = sc[b];
    end

    // Bridge stays off while shorted or in thermal shutdown.
    assign bridge_en = ~sc & {NB{~temp_shut}};

    bfm_status_enc #(.NB(NB)) u_enc (
        .clk(clk), .rst_n(rst_n), .ol(ol), .sc(sc), .temp_warn(temp_warn),
        .err1_n(err1_n), .err2_n(err2_n)
    );
endmodule

// File: tb/sim_bridge_fault_monitor.sv
`timescale 1ns/100ps
module sim_bridge_fault_monitor;
    localparam int NB = 2;
    localparam int CPU = 2;
    localparam int T_OL = 15*CPU, T_SCD = 45*CPU, T_SCC = 30*CPU;
    localparam int T_RP = 3*CPU, T_RI = 1*CPU;

    logic clk = 0, rst_n = 0;
    logic [NB-1:0] dir = '0, recirc = '0, shrt = '0;
    logic [2*NB-1:0] code = '1;
    logic warn = 0, shut = 0;
    logic e1, e2;
    logic [NB-1:0] en;
    logic [2*NB-1:0] st;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bridge_fault_monitor #(.NB(NB), .CYC_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .dir(dir), .code(code), .recirc(recirc),
        .short_det(shrt), .temp_warn(warn), .temp_shut(shut),
        .err1_n(e1), .err2_n(e2), .bridge_en(en), .fault_status(st));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int errs();
        return {e1, e2};
    endfunction

    task automatic prep();
        code = '1; shrt = '0; recirc = '0; warn = 0; shut = 0;
        step(5);
        code = 4'b0101;
        step(30);
    endtask

    task automatic pulse_rc(input int b);
        recirc[b] = 1; step(1); recirc[b] = 0;
    endtask

    task automatic t_reset();
        chk(st == 0, "R1 status", st, 0);
        chk(errs() == 3, "R1 err lines", errs(), 3);
        chk(en == 2'b11, "R1 enables", en, 3);
    endtask

    task automatic t_recirc_ok(input int b);
        prep();
        dir[b] = ~dir[b]; step(3); pulse_rc(b); step(T_OL + 5);
        chk(st[2*b] == 0, "R2 no open load", st[2*b], 0);
        chk(errs() == 3, "R2 err lines", errs(), 3);
    endtask

    task automatic t_open_load(input int b);
        prep();
        dir[b] = ~dir[b]; step(1); step(T_OL - 2);
        chk(st[2*b] == 0, "R3 not early", st[2*b], 0);
        step(4);
        chk(st[2*b] == 1, "R3 open load set", st[2*b], 1);
        chk(errs() == 1, "R3 err lines L,H", errs(), 1);
    endtask

    task automatic t_hold();
        prep();
        code[1:0] = 2'b10; step(30);
        dir[0] = ~dir[0]; step(2); pulse_rc(0); step(T_OL + 5);
        chk(st[0] == 1, "R4 hold reversal", st[0], 1);
    endtask

    task automatic t_windows();
        prep();
        dir[0] = ~dir[0]; step(2); code[1:0] = 2'b00; pulse_rc(0); step(T_OL + 5);
        chk(st[0] == 1, "R5 code after reversal", st[0], 1);
        prep();
        code[1:0] = 2'b00; step(3); dir[0] = ~dir[0]; step(2); pulse_rc(0); step(T_OL + 5);
        chk(st[0] == 1, "R5 reversal after code", st[0], 1);
    endtask

    task automatic t_short();
        prep();
        shrt[0] = 1; step(1); step(T_SCC - 2);
        chk(st[1] == 0 && en[0] == 1, "R6 short not early", st[1], 0);
        step(4);
        chk(st[1] == 1, "R6 short flag", st[1], 1);
        chk(en[0] == 0, "R7 bridge disabled", en[0], 0);
        chk(errs() == 2, "R6 err lines H,L", errs(), 2);
        shrt[0] = 0; step(20);
        chk(en[0] == 0 && st[1] == 1, "R7 disable held", en[0], 0);
        dir[0] = ~dir[0]; step(1); pulse_rc(0); step(T_RP - 3);
        chk(st[1] == 1, "R8 clear not early", st[1], 1);
        step(4);
        chk(st[1] == 0 && en[0] == 1, "R7 enable restored", en[0], 1);
    endtask

    task automatic t_short_dir();
        prep();
        shrt[1] = 1; step(20);
        dir[1] = ~dir[1]; step(1); step(T_SCD - 2);
        chk(st[3] == 0, "R6 reversal restarts short", st[3], 0);
        step(4);
        chk(st[3] == 1, "R6 short after reversal", st[3], 1);
    endtask

    task automatic t_clear();
        t_open_load(0);
        dir[0] = ~dir[0]; step(1); pulse_rc(0); step(T_RP - 3);
        chk(st[0] == 1, "R8 ol clear not early", st[0], 1);
        step(4);
        chk(st[0] == 0, "R8 ol cleared by reversal", st[0], 0);
        step(T_OL);
        chk(st[0] == 0, "R8 stays clear", st[0], 0);
        t_open_load(1);
        code[3:2] = 2'b11; step(T_RI + 3);
        chk(st[2] == 0, "R8 ol cleared by off code", st[2], 0);
        chk(errs() == 3, "R8 err lines", errs(), 3);
        shrt[1] = 1; step(T_SCD + 5);
        chk(st[3] == 0 && en[1] == 1, "R8 short ignored at off", st[3], 0);
    endtask

    task automatic t_thermal();
        t_open_load(0);
        warn = 1; step(2);
        chk(errs() == 0, "R9 warn L,L", errs(), 0);
        warn = 0; step(2);
        chk(errs() == 1, "R9 warn released", errs(), 1);
        shut = 1; step(1);
        chk(en == 0, "R10 shutdown", en, 0);
        shut = 0; step(1);
        chk(en == 2'b11, "R10 released", en, 3);
    endtask

    task automatic t_indep();
        prep();
        shrt[1] = 1; step(T_SCC + 4);
        chk(st == 4'b1000, "R11 only bridge1 short", st, 8);
        chk(en == 2'b01, "R11 bridge0 enabled", en, 1);
        dir[0] = ~dir[0]; step(T_OL + 4);
        chk(st == 4'b1001, "R11 bridge0 open load", st, 9);
        chk(errs() == 2, "R6 short over open load", errs(), 2);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            report();
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1;
        step(2);
        t_reset();
        t_recirc_ok(0);
        t_recirc_ok(1);
        t_open_load(0);
        t_open_load(1);
        t_hold();
        t_windows();
        t_short();
        t_short_dir();
        t_clear();
        t_thermal();
        t_indep();
        done = 1;
        report();
        $finish;
    end
endmodule